// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit timer/counter peripheral that sits on a simple byte-wide register bus. One counter and one 16-bit shared reload/capture register serve five behaviours. The control and mode registers select the behaviour through a fixed priority. The behaviours are: stopped, serial baud-rate tick generation, 16-bit capture, up-only auto-reload (which can also drive a clock-out pin), and direction-controlled up/down auto-reload.

The counter advances either on every system clock or on falling edges of an event pin. A second pin, the trigger pin, does one of three jobs depending on the behaviour: it takes a snapshot of the counter, it forces a reload, or it sets the counting direction. Both pins pass through a two-flop synchronizer, and a falling edge is seen as previous sample 1 and current sample 0.

The block has three outputs:
- an overflow pulse that a serial port uses for its bit clocks;
- a clock-out pin that toggles on each overflow;
- an interrupt request built from two sticky flags.

Top module: `tmr16_multimode`

## Requirements
- R1: After reset every register reads 0x00, and ser_tick, clk_out and irq are 0. The register map is: address 0 control, 1 mode, 2 count low, 3 count high, 4 reload low, 5 reload high. Control bits 7..0 are: overflow flag, external flag, receive-clock select, transmit-clock select, external enable, run, event select, capture select. Mode bit 1 is clock-out enable and bit 0 is down-count enable; mode bits 7..2 read 0.
- R2: While run=0 the counter holds its value, and trigger-pin edges have no effect on the flags or on the reload register.
- R3: With run=1 and event select=0, the counter advances once per clock, starting at the edge after the one that wrote run=1.
- R4: With event select=1, the counter advances once per synchronized falling edge of the event pin.
- R5: In up-only auto-reload (capture select=0, down-count enable=0), a tick at 0xFFFF loads the reload register into the counter and sets the overflow flag.
- R6: In capture mode, a tick at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag. With external enable=1, a trigger falling edge copies the counter into the reload register and sets the external flag.
- R7: In up-only auto-reload with external enable=1, a trigger falling edge loads the reload value into the counter and sets the external flag. With external enable=0 the edge is ignored.
- R8: With down-count enable=1, trigger level 1 counts up, reloading at 0xFFFF. Trigger level 0 counts down, and a tick at count equal to the reload value wraps to 0xFFFF. Each such overflow sets the overflow flag and toggles the external flag. Trigger edges cause no reload.
- R9: If either serial-clock select bit is 1, the counter reloads on every overflow whatever capture select holds. In that case ser_tick pulses for one cycle after each overflow and the overflow flag is not set.
- R10: In up-only auto-reload with clock-out enable=1, clk_out toggles on each overflow.
- R11: irq = overflow flag OR (external flag AND NOT down-count enable).
- R12: Flags change under software only by a control write. A hardware set in the same cycle as a software write of 0 wins.
- R13: A bus write to a counter or reload byte replaces that byte. The other byte keeps its value, and counting, reload and capture are skipped for that register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| evt_pin | input | 1 | External count-event pin |
| trig_pin | input | 1 | External trigger / direction pin |
| ser_tick | output | 1 | One-cycle overflow pulse for serial bit clocks |
| clk_out | output | 1 | Programmable clock-out pin |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall in the same cycle: a counter overflow that sets the overflow flag, and a software write to the control register that clears it. The bench provokes this in capture mode by starting the counter at 0xFFFE. The run write lands at one edge and the counter reaches 0xFFFF at the next. The clearing write is then placed so that it is sampled at the very edge where the overflow happens. The bench judges the result by reading back a counter of 0x0000 with the overflow flag still set. It then issues a plain clearing write, which must drop the flag.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

  typedef enum logic [2:0] {
    MD_OFF,
    MD_BAUD,
    MD_CAPT,
    MD_RELOAD,
    MD_UPDN
  } tmr_mode_e;

  // Control register layout, bit 7 down to bit 0.
  typedef struct packed {
    logic ovf_flag;
    logic ext_flag;
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic run;
    logic evt_sel;
    logic cap_sel;
  } tmr_ctrl_t;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_MODE   = 3'd1;
  localparam logic [2:0] ADDR_CNT_LO = 3'd2;
  localparam logic [2:0] ADDR_CNT_HI = 3'd3;
  localparam logic [2:0] ADDR_RLD_LO = 3'd4;
  localparam logic [2:0] ADDR_RLD_HI = 3'd5;

endpackage

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign fall  = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmr_mode_e    mode,
  input  logic         evt_sel,
  input  logic         ext_en,
  input  logic         evt_fall,
  input  logic         trig_fall,
  input  logic         trig_lvl,
  input  logic         cnt_wr_lo,
  input  logic         cnt_wr_hi,
  input  logic         rld_wr_lo,
  input  logic         rld_wr_hi,
  input  logic [7:0]   wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         ovf_evt,
  output logic         trig_evt
);

  localparam int HI = W - 8;
  localparam logic [W-1:0] ONES = '1;

  logic         tick, count_up, at_limit;
  logic         cnt_wr_any, rld_wr_any;
  logic [W-1:0] cnt_step, cnt_d, rld_d;
  logic         cnt_en, rld_en;

  always_comb begin
    cnt_wr_any = cnt_wr_lo | cnt_wr_hi;
    rld_wr_any = rld_wr_lo | rld_wr_hi;
    tick       = (mode != MD_OFF) && (evt_sel ? evt_fall : 1'b1);
    count_up   = (mode != MD_UPDN) || trig_lvl;
    at_limit   = count_up ? (cnt_q == ONES) : (cnt_q == rld_q);
    ovf_evt    = tick && at_limit;
    trig_evt   = ext_en && trig_fall && (mode == MD_CAPT || mode == MD_RELOAD);

    if (ovf_evt) begin
      if (mode == MD_CAPT)  cnt_step = '0;
      else if (count_up)    cnt_step = rld_q;
      else                  cnt_step = ONES;
    end else if (count_up) begin
      cnt_step = cnt_q + 1'b1;
    end else begin
      cnt_step = cnt_q - 1'b1;
    end

    cnt_d = cnt_q;
    if (cnt_wr_any) begin
      if (cnt_wr_lo) cnt_d[7:0] = wdata;
      if (cnt_wr_hi) cnt_d[W-1:8] = wdata[HI-1:0];
    end else if (trig_evt && mode == MD_RELOAD) begin
      cnt_d = rld_q;
    end else if (tick) begin
      cnt_d = cnt_step;
    end
    cnt_en = cnt_wr_any | tick | (trig_evt && mode == MD_RELOAD);

    rld_d = rld_q;
    if (rld_wr_any) begin
      if (rld_wr_lo) rld_d[7:0] = wdata;
      if (rld_wr_hi) rld_d[W-1:8] = wdata[HI-1:0];
    end else if (trig_evt && mode == MD_CAPT) begin
      rld_d = cnt_q;
    end
    rld_en = rld_wr_any | (trig_evt && mode == MD_CAPT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (rld_en) rld_q <= rld_d;
    end
  end

  a_r5_reload_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_RELOAD && tick && cnt_q == ONES && !cnt_wr_any && !trig_evt)
      |=> cnt_q == $past(rld_q));

  a_r6_capture_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CAPT && trig_evt && !rld_wr_any) |=> rld_q == $past(cnt_q));

  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_OFF && !cnt_wr_any) |=> $stable(cnt_q));

  a_r8_down_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_UPDN && tick && !trig_lvl && cnt_q == rld_q && !cnt_wr_any)
      |=> cnt_q == ONES);

endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       mode_wr,
  input  logic [7:0] wdata,
  input  logic       ovf_evt,
  input  logic       trig_evt,
  output tmr_ctrl_t  ctrl_q,
  output logic [1:0] mode_q,
  output tmr_mode_e  mode_sel,
  output logic       ser_tick,
  output logic       clk_out,
  output logic       irq
);

  tmr_ctrl_t  ctrl_d;
  logic [1:0] mode_d;
  logic       clkout_en, down_en, baud;
  logic       tick_d, clk_out_d;

  always_comb begin
    clkout_en = mode_q[1];
    down_en   = mode_q[0];
    baud      = ctrl_q.rx_sel | ctrl_q.tx_sel;

    if (!ctrl_q.run)         mode_sel = MD_OFF;
    else if (baud)           mode_sel = MD_BAUD;
    else if (ctrl_q.cap_sel) mode_sel = MD_CAPT;
    else if (down_en)        mode_sel = MD_UPDN;
    else                     mode_sel = MD_RELOAD;

    ctrl_d = ctrl_wr ? tmr_ctrl_t'(wdata) : ctrl_q;
    ctrl_d.ovf_flag = ctrl_d.ovf_flag | (ovf_evt && !baud);
    ctrl_d.ext_flag = (ctrl_d.ext_flag | trig_evt) ^ (ovf_evt && mode_sel == MD_UPDN);

    mode_d    = mode_wr ? wdata[1:0] : mode_q;
    tick_d    = ovf_evt && mode_sel == MD_BAUD;
    clk_out_d = clk_out ^ (ovf_evt && clkout_en && mode_sel == MD_RELOAD);

    irq = ctrl_q.ovf_flag | (ctrl_q.ext_flag & ~down_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      ser_tick <= 1'b0;
      clk_out  <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      if (mode_wr) mode_q <= mode_d;
      ser_tick <= tick_d;
      clk_out  <= clk_out_d;
    end
  end

  a_r9_no_ovf_flag_in_baud: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ctrl_wr) |=> !$rose(ctrl_q.ovf_flag));

  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && ctrl_q.ovf_flag) |=> ctrl_q.ovf_flag);

  a_r9_tick_only_baud: assert property (@(posedge clk) disable iff (!rst_n)
    ser_tick |-> $past(mode_sel == MD_BAUD && ovf_evt));

  a_r10_clkout_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_out) |-> $past(ovf_evt));

endmodule

// File: rtl/tmr16_multimode.sv
module tmr16_multimode
  import tmr16_pkg::*;
#(
  parameter int W         = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       evt_pin,
  input  logic       trig_pin,
  output logic       ser_tick,
  output logic       clk_out,
  output logic       irq
);

  localparam int NPINS = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NPINS-1:0] pins, pin_lvl, pin_fall;
  tmr_ctrl_t        ctrl_q;
  logic [1:0]       mode_q;
  tmr_mode_e        mode_sel;
  logic [W-1:0]     cnt_q, rld_q;
  logic             ovf_evt, trig_evt;
  logic [2*W-1:0]   regs16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign pins = {trig_pin, evt_pin};

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    tmr16_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
      .clk   (clk),
      .rst_n (rst_int_n),
      .pin   (pins[g]),
      .level (pin_lvl[g]),
      .fall  (pin_fall[g])
    );
  end

  tmr16_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ctrl_wr  (bus_wr && bus_addr == ADDR_CTRL),
    .mode_wr  (bus_wr && bus_addr == ADDR_MODE),
    .wdata    (bus_wdata),
    .ovf_evt  (ovf_evt),
    .trig_evt (trig_evt),
    .ctrl_q   (ctrl_q),
    .mode_q   (mode_q),
    .mode_sel (mode_sel),
    .ser_tick (ser_tick),
    .clk_out  (clk_out),
    .irq      (irq)
  );

  tmr16_core #(.W(W)) u_core (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .mode      (mode_sel),
    .evt_sel   (ctrl_q.evt_sel),
    .ext_en    (ctrl_q.ext_en),
    .evt_fall  (pin_fall[0]),
    .trig_fall (pin_fall[1]),
    .trig_lvl  (pin_lvl[1]),
    .cnt_wr_lo (bus_wr && bus_addr == ADDR_CNT_LO),
    .cnt_wr_hi (bus_wr && bus_addr == ADDR_CNT_HI),
    .rld_wr_lo (bus_wr && bus_addr == ADDR_RLD_LO),
    .rld_wr_hi (bus_wr && bus_addr == ADDR_RLD_HI),
    .wdata     (bus_wdata),
    .cnt_q     (cnt_q),
    .rld_q     (rld_q),
    .ovf_evt   (ovf_evt),
    .trig_evt  (trig_evt)
  );

  always_comb begin
    regs16 = {rld_q, cnt_q};
    unique case (bus_addr)
      ADDR_CTRL:   bus_rdata = ctrl_q;
      ADDR_MODE:   bus_rdata = {6'b0, mode_q};
      ADDR_CNT_LO: bus_rdata = regs16[7:0];
      ADDR_CNT_HI: bus_rdata = 8'(regs16[W-1:8]);
      ADDR_RLD_LO: bus_rdata = regs16[W+7:W];
      ADDR_RLD_HI: bus_rdata = 8'(regs16[2*W-1:W+8]);
      default:     bus_rdata = 8'h00;
    endcase
  end

endmodule

// File: tb/tb_tmr16_multimode.sv
module tb_tmr16_multimode;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       evt_pin = 1'b1;
  logic       trig_pin = 1'b1;
  logic       ser_tick, clk_out, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tmr16_multimode dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_pin(evt_pin),
    .trig_pin(trig_pin), .ser_tick(ser_tick), .clk_out(clk_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // All tasks are entered and left at a falling clock edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); d = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set16(input logic [2:0] a, input logic [15:0] v);
    wr(a, v[7:0]); wr(a + 3'd1, v[15:8]);
  endtask

  task automatic trig_fall_pulse();
    trig_pin = 1'b1; idle(4); trig_pin = 1'b0; idle(6); trig_pin = 1'b1; idle(4);
  endtask

  // Reference: n ticks of the auto-reload counter.
  function automatic logic [15:0] mdl(input logic [15:0] s, input logic [15:0] r,
                                      input bit updn, input bit up, input int n,
                                      output int ovs);
    logic [15:0] c = s;
    ovs = 0;
    for (int i = 0; i < n; i++) begin
      if (updn && !up) begin
        if (c == r) begin c = 16'hFFFF; ovs++; end else c = c - 1'b1;
      end else begin
        if (c == 16'hFFFF) begin c = r; ovs++; end else c = c + 1'b1;
      end
    end
    return c;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    int          ovs, tog, pulses;
    bit          prev;

    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), b);
      chk($sformatf("R1 reg%0d reset", a), b, 8'h00);
    end
    chk("R1 outputs reset", {ser_tick, clk_out, irq}, 3'b000);
    wr(3'd1, 8'hFF); rd(3'd1, b);
    chk("R1 mode upper bits read 0", b, 8'h03);
    wr(3'd1, 8'h00);

    // R2 stopped: counter holds, trigger ignored
    set16(3'd2, 16'h1234);
    wr(3'd0, 8'h08);
    idle(10);
    trig_fall_pulse();
    rd16(3'd2, v); chk("R2 hold while stopped", v, 16'h1234);
    rd(3'd0, b);   chk("R2 no ext flag while stopped", b, 8'h08);
    rd16(3'd4, v); chk("R2 reload untouched", v, 16'h0000);

    // R3 timer: run at P0, 9 idle edges, stop edge -> 10 increments
    wr(3'd0, 8'h04); idle(9); wr(3'd0, 8'h00);
    rd16(3'd2, v); chk("R3 ten clock ticks", v, 16'h123E);

    // R4 event counting, 5 falling edges
    set16(3'd2, 16'h0100);
    wr(3'd0, 8'h06);
    for (int i = 0; i < 5; i++) begin
      evt_pin = 1'b0; idle(4); evt_pin = 1'b1; idle(4);
    end
    idle(4);
    wr(3'd0, 8'h00);
    rd16(3'd2, v); chk("R4 five events", v, 16'h0105);

    // R6 capture by trigger (event mode, pin still: counter frozen)
    set16(3'd2, 16'hBEEF);
    wr(3'd0, 8'h0F);
    trig_fall_pulse();
    rd16(3'd4, v); chk("R6 capture value", v, 16'hBEEF);
    rd(3'd0, b);   chk("R6 ext flag set", b[6], 1'b1);
    chk("R11 irq from ext flag", irq, 1'b1);
    rd16(3'd2, v); chk("R6 counter unchanged by capture", v, 16'hBEEF);
    wr(3'd1, 8'h01);
    chk("R11 ext masked by down-count enable", irq, 1'b0);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h00);
    chk("R12 software clear of ext flag", irq, 1'b0);

    // R6 + R12: wrap to 0 at the same edge as a clearing control write
    set16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h05); idle(1); wr(3'd0, 8'h01);
    rd16(3'd2, v); chk("R6 capture-mode wrap to zero", v, 16'h0000);
    rd(3'd0, b);   chk("R12 hardware set beats software clear", b[7], 1'b1);
    wr(3'd0, 8'h00); rd(3'd0, b);
    chk("R12 later clear drops flag", b[7], 1'b0);

    // R7 trigger-forced reload, then ignored with external enable off
    set16(3'd2, 16'h1000); set16(3'd4, 16'hABCD);
    wr(3'd0, 8'h0E);
    trig_fall_pulse();
    rd16(3'd2, v); chk("R7 trigger reload", v, 16'hABCD);
    rd(3'd0, b);   chk("R7 ext flag set on reload", b[6], 1'b1);
    wr(3'd0, 8'h06);
    set16(3'd2, 16'h1000);
    trig_fall_pulse();
    rd16(3'd2, v); chk("R7 trigger ignored when disabled", v, 16'h1000);
    rd(3'd0, b);   chk("R7 no ext flag when disabled", b[6], 1'b0);
    wr(3'd0, 8'h00);

    // R13 byte write while running
    set16(3'd2, 16'h2000);
    wr(3'd0, 8'h04); wr(3'd3, 8'h55); wr(3'd0, 8'h00);
    rd16(3'd2, v); chk("R13 byte write replaces, no count that cycle", v, 16'h5501);

    // R9 baud generation (capture select set but ignored)
    set16(3'd2, 16'hFFFD); set16(3'd4, 16'hFFF0);
    wr(3'd0, 8'h15);
    pulses = 0; prev = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ser_tick) pulses++;
      if (ser_tick && prev) chk("R9 tick is one cycle wide", 1, 0);
      prev = ser_tick;
    end
    rd(3'd0, b); chk("R9 no overflow flag in baud mode", b[7], 1'b0);
    wr(3'd0, 8'h00);
    chk("R9 three ser_tick pulses", pulses, 3);
    rd16(3'd2, v);
    chk("R9 reload forced on overflow", v, mdl(16'hFFFD, 16'hFFF0, 0, 1, 41, ovs));

    // R10 clock-out
    wr(3'd1, 8'h02);
    set16(3'd2, 16'hFFF8); set16(3'd4, 16'hFFF8);
    tog = 0; prev = clk_out;
    wr(3'd0, 8'h04);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (clk_out != prev) tog++;
      prev = clk_out;
    end
    wr(3'd0, 8'h00);
    chk("R10 clk_out toggles per overflow", tog, 4);
    wr(3'd1, 8'h00);

    // R5 / R8 / R11 random auto-reload runs
    for (int it = 0; it < 30; it++) begin
      logic [15:0] s, r, e;
      bit updn, up;
      int m;
      updn = ($urandom % 2) == 1;
      up   = updn ? (($urandom % 2) == 1) : 1'b1;
      r    = 16'($urandom);
      s    = up ? 16'hFFFF - 16'($urandom % 20) : r + 16'($urandom % 20);
      m    = $urandom % 40;
      wr(3'd0, 8'h00);
      wr(3'd1, {7'b0, updn});
      set16(3'd2, s); set16(3'd4, r);
      trig_pin = updn ? up : 1'($urandom % 2);
      idle(6);
      wr(3'd0, 8'h04);
      idle(m);
      void'(mdl(s, r, updn, up, m, ovs));
      rd(3'd0, b);
      chk(updn ? "R8 overflow flag" : "R5 overflow flag", b[7], ovs > 0);
      chk(updn ? "R8 ext flag toggles" : "R5 ext flag clear", b[6], updn ? ovs[0] : 1'b0);
      chk("R11 irq", irq, ovs > 0);
      wr(3'd0, 8'h00);
      e = mdl(s, r, updn, up, m + 1, ovs);
      rd16(3'd2, v);
      chk(updn ? "R8 counter value" : "R5 counter value", v, e);
    end
    trig_pin = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule